// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a small set of control registers that exist once per hardware instance but appear at a single bus address. Instances are arranged as groups of instances. A steering selector register, at its own address outside the replicated window, holds a group number, an instance number and a broadcast flag. Together these decide which copy a bus access reaches. A write made with the broadcast flag set lands in every live copy of the addressed register. A write made with the flag clear lands only in the steered copy. A read always returns one copy: the steered one.

Each instance carries two liveness inputs, a fuse-enable bit and a power-on bit. An instance is live only when both bits are high. An access steered at a dead instance, or at a group or instance number beyond the implemented range, is terminated without any error. A terminated read returns zero and a terminated write changes nothing. After every unicast write the selector puts its broadcast flag back on by itself, so software always finds the bank in broadcast mode between operations.

The bus is a plain 32-bit register port. Read data is registered and appears one cycle after the address.

Top module: `rr_steer_bank`

## Requirements
- R1: After reset every copy of every replicated register reads 0, and the selector reads 32'h8000_0000 (broadcast on, group 0, instance 0).
- R2: A write to a replicated address (addr < NUM_REGS) while the selector's broadcast flag is set stores the data in that register of every live instance.
- R3: A write to a replicated address while the broadcast flag is clear stores the data only in the instance whose index equals group*NUM_INSTS+instance.
- R4: A read of a replicated address returns the steered instance's copy whether the broadcast flag is set or clear.
- R5: A read steered to an instance whose fuse-enable bit or power-on bit is low returns zero.
- R6: A unicast write steered to a dead instance is dropped, and that copy keeps its old value once the instance is live again.
- R7: During a broadcast write, dead instances keep their old value while all live instances take the new one.
- R8: In the cycle after a unicast write to the replicated window, the selector's broadcast flag is 1 again and its group and instance fields are unchanged.
- R9: A group field >= NUM_GROUPS or an instance field >= NUM_INSTS counts as terminated: reads return zero and unicast writes change no copy.
- R10: Read data is registered: it holds its previous value until the next rising clock edge, then shows the value for the address presented before that edge.
- R11: The selector at SEL_ADDR (default 8'h80) is read and written as one word: instance number in bits [3:0], group number in bits [11:8], broadcast flag in bit 31, and all other bits read 0.
- R12: An address that is neither in the replicated window nor SEL_ADDR reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address of the access |
| we | input | 1 | Write strobe for the current cycle |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, one cycle after addr |
| fuse_ok | input | NUM_GROUPS*NUM_INSTS | Per-instance fuse enable, bit index group*NUM_INSTS+instance |
| pwr_ok | input | NUM_GROUPS*NUM_INSTS | Per-instance power-on flag, same indexing |

## Verification
Some properties are checked by the assertions on every cycle. These are: zero read data for terminated, out-of-range and unmapped reads; the exact selector word on readback; the return of the broadcast flag after a unicast write; at most one copy written per unicast write; and no write ever reaching a dead or out-of-range copy. Other behaviour can only be shown by the bench's scenarios, because it depends on stored history. The bench reads every copy after broadcast and unicast writes. It checks that copies skipped while dead still hold their older contents after they come back to life. It also checks that unmapped writes leave all 128 copies unchanged.

// File: rtl/rr_steer_pkg.sv
package rr_steer_pkg;

   localparam int SEL_FW       = 4;
   localparam int SEL_INST_LSB = 0;
   localparam int SEL_GRP_LSB  = 8;
   localparam int SEL_MC_BIT   = 31;

   typedef struct packed {
      logic              mc;
      logic [SEL_FW-1:0] grp;
      logic [SEL_FW-1:0] inst;
   } steer_t;

   localparam steer_t STEER_RESET = '{mc: 1'b1, grp: '0, inst: '0};

   function automatic logic [31:0] steer_pack(input steer_t s);
      logic [31:0] w;
      w = '0;
      w[SEL_MC_BIT]                 = s.mc;
      w[SEL_GRP_LSB  +: SEL_FW]     = s.grp;
      w[SEL_INST_LSB +: SEL_FW]     = s.inst;
      return w;
   endfunction

   function automatic steer_t steer_unpack(input logic [31:0] w);
      steer_t s;
      s.mc   = w[SEL_MC_BIT];
      s.grp  = w[SEL_GRP_LSB  +: SEL_FW];
      s.inst = w[SEL_INST_LSB +: SEL_FW];
      return s;
   endfunction

endpackage

// File: rtl/rr_steer_sel.sv
module rr_steer_sel
   import rr_steer_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] load_word,
   input  logic        restore_mc,
   output steer_t      sel_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= STEER_RESET;
      end else if (load) begin
         sel_q <= steer_unpack(load_word);
      end else if (restore_mc) begin
         sel_q.mc <= 1'b1;
      end
   end

endmodule

// File: rtl/rr_steer_store.sv
module rr_steer_store #(
   parameter int NUM_COPIES = 16,
   parameter int NUM_REGS   = 8,
   parameter int DATA_W     = 32,
   localparam int RIW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_COPIES-1:0]      wen,
   input  logic [RIW-1:0]             widx,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [RIW-1:0]             ridx,
   output logic [NUM_COPIES*DATA_W-1:0] rd_words
);

   for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
      logic [DATA_W-1:0] regs [NUM_REGS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
               regs[r] <= '0;
            end
         end else if (wen[k]) begin
            regs[widx] <= wdata;
         end
      end

      assign rd_words[k*DATA_W +: DATA_W] = regs[ridx];
   end

endmodule

// File: rtl/rr_steer_rdmux.sv
module rr_steer_rdmux
   import rr_steer_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INSTS  = 4,
   parameter int DATA_W     = 32,
   localparam int NT        = NUM_GROUPS * NUM_INSTS
) (
   input  logic [NT*DATA_W-1:0] rd_words,
   input  steer_t               sel,
   input  logic [NT-1:0]        present,
   output logic [DATA_W-1:0]    word,
   output logic                 steer_ok
);

   always_comb begin
      word     = '0;
      steer_ok = 1'b0;
      for (int k = 0; k < NT; k++) begin
         if (int'(sel.grp) == (k / NUM_INSTS) &&
             int'(sel.inst) == (k % NUM_INSTS) && present[k]) begin
            word     = rd_words[k*DATA_W +: DATA_W];
            steer_ok = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rr_steer_bank.sv
module rr_steer_bank
   import rr_steer_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INSTS  = 4,
   parameter int NUM_REGS   = 8,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h80,
   localparam int NT        = NUM_GROUPS * NUM_INSTS,
   localparam int RIW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NT-1:0]     fuse_ok,
   input  logic [NT-1:0]     pwr_ok
);

   if (DATA_W != 32) begin : g_bad_dw
      $error("rr_steer_bank: DATA_W must be 32");
   end
   if (NUM_GROUPS < 1 || NUM_GROUPS > (1 << SEL_FW)) begin : g_bad_grp
      $error("rr_steer_bank: NUM_GROUPS out of selector range");
   end
   if (NUM_INSTS < 1 || NUM_INSTS > (1 << SEL_FW)) begin : g_bad_inst
      $error("rr_steer_bank: NUM_INSTS out of selector range");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("rr_steer_bank: NUM_REGS must be a power of two >= 2");
   end
   if (int'(SEL_ADDR) < NUM_REGS) begin : g_bad_sel
      $error("rr_steer_bank: SEL_ADDR overlaps the replicated window");
   end

   logic              in_win;
   logic              sel_hit;
   logic [RIW-1:0]    ridx;
   logic [NT-1:0]     present;
   logic [NT-1:0]     inst_wen;
   steer_t            sel_q;
   logic [NT*DATA_W-1:0] rd_words;
   logic [DATA_W-1:0] mux_word;
   logic              mux_ok;
   logic [DATA_W-1:0] rdata_q;

   assign in_win  = int'(addr) < NUM_REGS;
   assign sel_hit = (addr == SEL_ADDR);
   assign ridx    = addr[RIW-1:0];
   assign present = fuse_ok & pwr_ok;

   rr_steer_sel u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (we && sel_hit),
      .load_word  (wdata),
      .restore_mc (we && in_win && !sel_q.mc),
      .sel_q      (sel_q)
   );

   for (genvar k = 0; k < NT; k++) begin : g_wdec
      localparam int G = k / NUM_INSTS;
      localparam int I = k % NUM_INSTS;
      assign inst_wen[k] = we && in_win && present[k] &&
                           (sel_q.mc || (sel_q.grp == SEL_FW'(G) && sel_q.inst == SEL_FW'(I)));
   end

   rr_steer_store #(
      .NUM_COPIES (NT),
      .NUM_REGS   (NUM_REGS),
      .DATA_W     (DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen      (inst_wen),
      .widx     (ridx),
      .wdata    (wdata),
      .ridx     (ridx),
      .rd_words (rd_words)
   );

   rr_steer_rdmux #(
      .NUM_GROUPS (NUM_GROUPS),
      .NUM_INSTS  (NUM_INSTS),
      .DATA_W     (DATA_W)
   ) u_rdmux (
      .rd_words (rd_words),
      .sel      (sel_q),
      .present  (present),
      .word     (mux_word),
      .steer_ok (mux_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (sel_hit) begin
         rdata_q <= steer_pack(sel_q);
      end else if (in_win && mux_ok) begin
         rdata_q <= mux_word;
      end else begin
         rdata_q <= '0;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/rr_steer_bank_chk.sv
module rr_steer_bank_chk
   import rr_steer_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INSTS  = 4,
   parameter int NUM_REGS   = 8,
   parameter int ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h80,
   localparam int NT        = NUM_GROUPS * NUM_INSTS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic [31:0]       rdata,
   input logic [NT-1:0]     fuse_ok,
   input logic [NT-1:0]     pwr_ok,
   input steer_t            sel_q,
   input logic [NT-1:0]     inst_wen
);

   logic c_win;
   logic c_range;
   logic c_live;

   assign c_win   = int'(addr) < NUM_REGS;
   assign c_range = int'(sel_q.grp) < NUM_GROUPS && int'(sel_q.inst) < NUM_INSTS;

   always_comb begin
      c_live = 1'b0;
      for (int k = 0; k < NT; k++) begin
         if (c_range && k == int'(sel_q.grp) * NUM_INSTS + int'(sel_q.inst)) begin
            c_live = fuse_ok[k] & pwr_ok[k];
         end
      end
   end

   // R5: terminated reads return zero
   a_r5_dead_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (c_win && !c_live) |=> (rdata == 32'h0));

   // R9: out-of-range steering reads zero
   a_r9_range_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (c_win && !c_range) |=> (rdata == 32'h0));

   // R9: out-of-range unicast steering writes nothing
   a_r9_range_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q.mc && !c_range) |-> (inst_wen == '0));

   // R12: unmapped reads return zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_win && addr != SEL_ADDR) |=> (rdata == 32'h0));

   // R11: selector readback layout
   a_r11_sel_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == SEL_ADDR) |=> (rdata == steer_pack($past(sel_q))));

   // R8: broadcast flag comes back after a unicast write
   a_r8_mc_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (we && c_win && !sel_q.mc) |=> (sel_q.mc && $stable(sel_q.grp) && $stable(sel_q.inst)));

   // R3: a unicast write reaches at most one copy
   a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q.mc) |-> ($countones(inst_wen) <= 1));

   // R7: dead copies never take a write
   a_r7_dead_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      ((inst_wen & ~(fuse_ok & pwr_ok)) == '0));

endmodule

bind rr_steer_bank rr_steer_bank_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .NUM_INSTS  (NUM_INSTS),
   .NUM_REGS   (NUM_REGS),
   .ADDR_W     (ADDR_W),
   .SEL_ADDR   (SEL_ADDR)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .we       (we),
   .rdata    (rdata),
   .fuse_ok  (fuse_ok),
   .pwr_ok   (pwr_ok),
   .sel_q    (sel_q),
   .inst_wen (inst_wen)
);

// File: tb/rr_steer_bank_tb_top.sv
`timescale 1ns/1ps
module rr_steer_bank_tb_top;

   localparam int NG = 4;
   localparam int NI = 4;
   localparam int NR = 8;
   localparam int NT = NG * NI;
   localparam logic [7:0] SEL = 8'h80;
   localparam logic [7:0] HOLE = 8'h20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [7:0]    addr;
   logic          we;
   logic [31:0]   wdata;
   logic [31:0]   rdata;
   logic [NT-1:0] fuse_ok;
   logic [NT-1:0] pwr_ok;

   always #4 clk = ~clk;

   rr_steer_bank dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .we      (we),
      .wdata   (wdata),
      .rdata   (rdata),
      .fuse_ok (fuse_ok),
      .pwr_ok  (pwr_ok)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] model [NT][NR];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a; we = 1'b0;
      @(negedge clk);
      v = rdata;
   endtask

   function automatic logic [31:0] sel_word(input logic mc, input int g, input int i);
      return (32'(mc) << 31) | (32'(g & 15) << 8) | 32'(i & 15);
   endfunction

   task automatic set_sel(input logic mc, input int g, input int i);
      wr(SEL, sel_word(mc, g, i));
   endtask

   task automatic sweep(input string req);
      logic [31:0] v;
      for (int k = 0; k < NT; k++) begin
         set_sel(1'b1, k / NI, k % NI);
         for (int r = 0; r < NR; r++) begin
            rd(8'(r), v);
            chk(req, v, model[k][r]);
         end
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0;
      fuse_ok = '1; pwr_ok = '1;
      for (int k = 0; k < NT; k++)
         for (int r = 0; r < NR; r++)
            model[k][r] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R11: reset selector word, all copies zero
      rd(SEL, v);
      chk("R1", v, 32'h8000_0000);
      sweep("R1");

      // R2: broadcast write to every register
      for (int r = 0; r < NR; r++) begin
         wr(8'(r), 32'hA000_0000 + 32'(r));
         for (int k = 0; k < NT; k++) model[k][r] = 32'hA000_0000 + 32'(r);
      end
      sweep("R2");

      // R3 / R8: unicast write to each copy of register 3
      for (int k = 0; k < NT; k++) begin
         set_sel(1'b0, k / NI, k % NI);
         wr(8'd3, 32'h3300_0000 | 32'(k));
         model[k][3] = 32'h3300_0000 | 32'(k);
         rd(SEL, v);
         chk("R8", v, sel_word(1'b1, k / NI, k % NI));
      end
      sweep("R3");

      // R4 / R11: read with broadcast flag clear
      set_sel(1'b0, 2, 1);
      rd(SEL, v);
      chk("R11", v, 32'h0000_0201);
      rd(8'd3, v);
      chk("R4", v, model[9][3]);
      rd(8'd6, v);
      chk("R4", v, model[9][6]);
      set_sel(1'b1, 3, 3);
      rd(8'd3, v);
      chk("R4", v, model[15][3]);

      // R5: fused-off copy 5 and power-gated copy 10 read zero
      fuse_ok[5] = 1'b0;
      pwr_ok[10] = 1'b0;
      set_sel(1'b1, 1, 1);
      rd(8'd0, v);
      chk("R5", v, 32'h0);
      set_sel(1'b1, 2, 2);
      rd(8'd3, v);
      chk("R5", v, 32'h0);

      // R7: broadcast write skips dead copies
      wr(8'd0, 32'h5555_0000);
      for (int k = 0; k < NT; k++)
         if (k != 5 && k != 10) model[k][0] = 32'h5555_0000;

      // R6: unicast write to dead copy dropped
      set_sel(1'b0, 1, 1);
      wr(8'd1, 32'hDEAD_0001);
      set_sel(1'b0, 2, 2);
      wr(8'd1, 32'hDEAD_0002);

      fuse_ok = '1;
      pwr_ok = '1;
      set_sel(1'b1, 1, 1);
      rd(8'd1, v);
      chk("R6", v, 32'hA000_0001);
      set_sel(1'b1, 2, 2);
      rd(8'd1, v);
      chk("R6", v, 32'hA000_0001);
      sweep("R7");

      // R9: out-of-range steering
      set_sel(1'b1, 5, 0);
      rd(8'd3, v);
      chk("R9", v, 32'h0);
      set_sel(1'b1, 0, 9);
      rd(8'd3, v);
      chk("R9", v, 32'h0);
      set_sel(1'b0, 0, 7);
      wr(8'd2, 32'hBAD0_0002);
      set_sel(1'b0, 6, 1);
      wr(8'd2, 32'hBAD0_0003);
      sweep("R9");

      // R12: unmapped address
      wr(HOLE, 32'hFFFF_FFFF);
      rd(HOLE, v);
      chk("R12", v, 32'h0);
      sweep("R12");

      // R10: read data changes only at the clock edge
      set_sel(1'b1, 1, 2);
      rd(SEL, v);
      chk("R10", v, 32'h8000_0102);
      addr = HOLE;
      #1;
      chk("R10", rdata, 32'h8000_0102);
      @(negedge clk);
      chk("R10", rdata, 32'h0);

      summary();
      $finish;
   end

endmodule